// File: doc/BRIEF.md
# Pattern Bank and Mirroring Translator

This block turns a 13-bit video-side pattern address into a 17-bit physical character-memory address. The upper five bits of the result are a 4 KiB bank number, chosen from two 5-bit bank registers according to one control bit. In wide mode a single register covers the whole 8 KiB pattern space, forced to an even bank. In split mode each 4 KiB half of the window has its own register. The lower twelve bits pass through from the video address.

The same control word carries a 2-bit mirroring field. From that field the block derives the nametable line that picks between the two physical nametable pages. Two codes tie every nametable access to one fixed page, one code follows video address bit 10, and one follows bit 11. The register contents come from elsewhere. Both outputs are registered, so each one reflects the inputs sampled at the previous rising clock edge.

Top module: `pattern_xlat`

## Requirements
- R1: While `rst` is high at a rising edge, `chr_addr` and `nt_sel` become all zeros at that edge.
- R2: Outputs are registered with a latency of one cycle: after each rising edge they reflect the inputs present at that edge, and they keep their value until the next edge.
- R3: `chr_addr[11:0]` equals bits 11:0 of the sampled `vid_addr`.
- R4: With `ctrl[4]` = 0 (wide mode), `chr_addr[16:12]` equals `{bank_lo[4:1], vid_addr[12]}`. In this mode `bank_lo[0]` and all of `bank_hi` have no effect.
- R5: With `ctrl[4]` = 1 (split mode) and `vid_addr[12]` = 0, `chr_addr[16:12]` equals `bank_lo`.
- R6: With `ctrl[4]` = 1 and `vid_addr[12]` = 1, `chr_addr[16:12]` equals `bank_hi`.
- R7: With `ctrl[1:0]` = 00, `nt_sel` is 0.
- R8: With `ctrl[1:0]` = 01, `nt_sel` is 1.
- R9: With `ctrl[1:0]` = 10, `nt_sel` equals `vid_addr[10]`.
- R10: With `ctrl[1:0]` = 11, `nt_sel` equals `vid_addr[11]`.
- R11: `ctrl[3:2]` has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_addr | input | 13 | Video-side pattern address |
| ctrl | input | 5 | Control word: bit 4 selects the bank mode, bits 1:0 select mirroring |
| bank_lo | input | 5 | Bank register for the lower half, or for the whole window in wide mode |
| bank_hi | input | 5 | Bank register for the upper half in split mode |
| chr_addr | output | 17 | Physical character-memory address |
| nt_sel | output | 1 | Nametable page select line |

## Verification
On every cycle after reset, the assertions compare the registered outputs against the inputs sampled one edge earlier. This covers the offset pass-through, the bank chosen in each mode and window half, each of the four mirroring codes, and the zeroed outputs after reset. Some behaviour only the bench scenarios can show: that the outputs hold between edges rather than following the inputs, and that the ignored bits (`ctrl[3:2]`, `bank_lo[0]` in wide mode, `bank_hi` in wide mode) leave the outputs unchanged. The bench shows this by changing only those bits and comparing the results.

// File: rtl/pattern_xlat_pkg.sv
package pattern_xlat_pkg;

    localparam int BANK_W = 5;
    localparam int OFS_W  = 12;
    localparam int VA_W   = OFS_W + 1;
    localparam int PA_W   = BANK_W + OFS_W;
    localparam int CTRL_W = 5;

    typedef enum logic {
        BMODE_WIDE  = 1'b0,
        BMODE_SPLIT = 1'b1
    } bank_mode_e;

    typedef enum logic [1:0] {
        MIR_PAGE0 = 2'b00,
        MIR_PAGE1 = 2'b01,
        MIR_VERT  = 2'b10,
        MIR_HORZ  = 2'b11
    } mirror_e;

    typedef struct packed {
        bank_mode_e bmode;
        logic [1:0] spare;
        mirror_e    mir;
    } ctrl_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [OFS_W-1:0]  ofs;
    } phys_t;

    function automatic ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] raw);
        return ctrl_t'(raw);
    endfunction

endpackage

// File: rtl/bank_pick.sv
module bank_pick
    import pattern_xlat_pkg::*;
#(
    parameter int BW = BANK_W
) (
    input  bank_mode_e    bmode,
    input  logic          half_hi,
    input  logic [BW-1:0] reg_lo,
    input  logic [BW-1:0] reg_hi,
    output logic [BW-1:0] bank
);
    always_comb begin
        if (bmode == BMODE_WIDE)
            bank = {reg_lo[BW-1:1], half_hi};
        else
            bank = half_hi ? reg_hi : reg_lo;
    end
endmodule

// File: rtl/mirror_pick.sv
module mirror_pick
    import pattern_xlat_pkg::*;
(
    input  mirror_e mir,
    input  logic    va10,
    input  logic    va11,
    output logic    nt
);
    always_comb begin
        unique case (mir)
            MIR_PAGE0: nt = 1'b0;
            MIR_PAGE1: nt = 1'b1;
            MIR_VERT:  nt = va10;
            MIR_HORZ:  nt = va11;
        endcase
    end
endmodule

// File: rtl/pattern_xlat.sv
module pattern_xlat
    import pattern_xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [VA_W-1:0]   vid_addr,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [BANK_W-1:0] bank_lo,
    input  logic [BANK_W-1:0] bank_hi,
    output logic [PA_W-1:0]   chr_addr,
    output logic              nt_sel
);
    ctrl_t             cw;
    logic [BANK_W-1:0] bank_c;
    logic              nt_c;
    phys_t             phys_c;
    phys_t             phys_q;
    logic              nt_q;

    assign cw = unpack_ctrl(ctrl);

    bank_pick #(.BW(BANK_W)) u_bank (
        .bmode  (cw.bmode),
        .half_hi(vid_addr[OFS_W]),
        .reg_lo (bank_lo),
        .reg_hi (bank_hi),
        .bank   (bank_c)
    );

    mirror_pick u_mir (
        .mir (cw.mir),
        .va10(vid_addr[10]),
        .va11(vid_addr[11]),
        .nt  (nt_c)
    );

    always_comb begin
        phys_c.bank = bank_c;
        phys_c.ofs  = vid_addr[OFS_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phys_q <= '0;
            nt_q   <= 1'b0;
        end else begin
            phys_q <= phys_c;
            nt_q   <= nt_c;
        end
    end

    assign chr_addr = phys_q;
    assign nt_sel   = nt_q;
endmodule

// File: rtl/pattern_xlat_chk.sv
module pattern_xlat_chk
    import pattern_xlat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [VA_W-1:0]   vid_addr,
    input logic [CTRL_W-1:0] ctrl,
    input logic [BANK_W-1:0] bank_lo,
    input logic [BANK_W-1:0] bank_hi,
    input logic [PA_W-1:0]   chr_addr,
    input logic              nt_sel
);
    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (chr_addr == '0 && nt_sel == 1'b0)); // R1

    AST_OFS_PASS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> chr_addr[OFS_W-1:0] == $past(vid_addr[OFS_W-1:0])); // R3

    AST_WIDE_BANK: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctrl[4])) |->
            chr_addr[PA_W-1:OFS_W] == {$past(bank_lo[BANK_W-1:1]), $past(vid_addr[OFS_W])}); // R4

    AST_SPLIT_LO: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctrl[4]) && !$past(vid_addr[OFS_W])) |->
            chr_addr[PA_W-1:OFS_W] == $past(bank_lo)); // R5

    AST_SPLIT_HI: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctrl[4]) && $past(vid_addr[OFS_W])) |->
            chr_addr[PA_W-1:OFS_W] == $past(bank_hi)); // R6

    AST_NT_FIXED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctrl[1])) |-> nt_sel == $past(ctrl[0])); // R7 R8

    AST_NT_VERT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctrl[1:0]) == 2'b10) |-> nt_sel == $past(vid_addr[10])); // R9

    AST_NT_HORZ: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctrl[1:0]) == 2'b11) |-> nt_sel == $past(vid_addr[11])); // R10
endmodule

bind pattern_xlat pattern_xlat_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .vid_addr(vid_addr),
    .ctrl    (ctrl),
    .bank_lo (bank_lo),
    .bank_hi (bank_hi),
    .chr_addr(chr_addr),
    .nt_sel  (nt_sel)
);

// File: tb/pattern_xlat_tb_top.sv
module pattern_xlat_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] vid_addr = '0;
    logic [4:0]  ctrl = '0;
    logic [4:0]  bank_lo = '0;
    logic [4:0]  bank_hi = '0;
    logic [16:0] chr_addr;
    logic        nt_sel;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pattern_xlat dut_i (
        .clk(clk), .rst(rst), .vid_addr(vid_addr), .ctrl(ctrl),
        .bank_lo(bank_lo), .bank_hi(bank_hi),
        .chr_addr(chr_addr), .nt_sel(nt_sel)
    );

    // row: ctrl, bank_lo, bank_hi, vid_addr, expected chr_addr, expected nt_sel
    localparam int NV = 12;
    localparam logic [45:0] VEC [NV] = '{
        {5'b00010, 5'h07, 5'h1F, 13'h0123, 17'h06123, 1'b0},
        {5'b00010, 5'h07, 5'h1F, 13'h1555, 17'h07555, 1'b1},
        {5'b10011, 5'h0A, 5'h15, 13'h0800, 17'h0A800, 1'b1},
        {5'b10011, 5'h0A, 5'h15, 13'h1400, 17'h15400, 1'b0},
        {5'b10000, 5'h1F, 5'h00, 13'h1FFF, 17'h00FFF, 1'b0},
        {5'b10001, 5'h1F, 5'h00, 13'h0FFF, 17'h1FFFF, 1'b1},
        {5'b01101, 5'h11, 5'h0E, 13'h0000, 17'h10000, 1'b1},
        {5'b00001, 5'h11, 5'h0E, 13'h0000, 17'h10000, 1'b1},
        {5'b00011, 5'h10, 5'h05, 13'h1800, 17'h11800, 1'b1},
        {5'b11110, 5'h03, 5'h1C, 13'h1C00, 17'h1CC00, 1'b1},
        {5'b00000, 5'h01, 5'h1F, 13'h0000, 17'h00000, 1'b0},
        {5'b00000, 5'h01, 5'h1F, 13'h1000, 17'h01000, 1'b0}
    };

    function automatic string row_tags(input int i);
        case (i)
            0:  return "R3 R4 R9";
            1:  return "R3 R4 R9";
            2:  return "R5 R10";
            3:  return "R6 R10";
            4:  return "R6 R7";
            5:  return "R5 R8";
            6:  return "R4 R8 R11";
            7:  return "R4 R8 R11";
            8:  return "R4 R10";
            9:  return "R6 R9 R11";
            default: return "R4 bank_lo bit0 ignored";
        endcase
    endfunction

    task automatic check(input string tag, input logic [16:0] ea, input logic en);
        n_vec++;
        if (chr_addr !== ea || nt_sel !== en) begin
            n_bad++;
            $display("FAIL %s: chr_addr=%h nt_sel=%b expected chr_addr=%h nt_sel=%b",
                     tag, chr_addr, nt_sel, ea, en);
        end
    endtask

    task automatic drive(input logic [4:0] c, input logic [4:0] lo,
                         input logic [4:0] hi, input logic [12:0] va);
        ctrl = c; bank_lo = lo; bank_hi = hi; vid_addr = va;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset with busy inputs
        drive(5'b11111, 5'h1F, 5'h1F, 13'h1FFF);
        repeat (3) @(negedge clk);
        check("R1 reset state", 17'h0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][45:41], VEC[i][40:36], VEC[i][35:31], VEC[i][30:18]);
            @(negedge clk);
            check($sformatf("vector %0d %s", i, row_tags(i)), VEC[i][17:1], VEC[i][0]);
        end

        // R2: output holds until the next edge, then follows
        drive(5'b10010, 5'h02, 5'h09, 13'h0400);
        @(negedge clk);
        check("R2 first load", 17'h02400, 1'b1);
        drive(5'b10011, 5'h02, 5'h09, 13'h1000);
        #1;
        check("R2 hold before edge", 17'h02400, 1'b1);
        @(negedge clk);
        check("R2 update after edge", 17'h09000, 1'b0);

        // R4: bank_hi has no effect in wide mode
        drive(5'b00000, 5'h0C, 5'h00, 13'h1ABC);
        @(negedge clk);
        check("R4 wide hi=00", 17'h0DABC, 1'b0);
        drive(5'b00000, 5'h0C, 5'h1F, 13'h1ABC);
        @(negedge clk);
        check("R4 wide hi=1F", 17'h0DABC, 1'b0);

        // R11: spare control bits have no effect
        drive(5'b10110, 5'h04, 5'h18, 13'h0C00);
        @(negedge clk);
        check("R11 spare=01", 17'h04C00, 1'b1);
        drive(5'b11010, 5'h04, 5'h18, 13'h0C00);
        @(negedge clk);
        check("R11 spare=10", 17'h04C00, 1'b1);

        // R1: reset mid-run clears outputs
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-run", 17'h0, 1'b0);
        rst = 1'b0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule